// File: doc/BRIEF.md
# Lane Drive Level Negotiator

This block turns the per-lane drive adjustment requests reported by a link partner into one common transmit drive setting that is applied to every active lane. Two request bytes are presented, each holding two 4-bit lane requests, together with the number of active lanes. The block reduces the requests to the worst case, which is the highest voltage swing and the highest pre-emphasis asked for by any active lane. It then clamps that pair against the capabilities listed in a small drive table.

The drive table holds up to `DEPTH` entries. Each entry is a supported (swing, pre-emphasis) pair and is loaded through a simple write port while the block is idle. A `start` pulse captures the requests. The block then walks the table twice, one entry per clock. The first pass finds the highest supported swing. The second pass finds the highest pre-emphasis among entries whose swing equals the swing just chosen. When a request reaches or passes its limit, the limit is used and a "maximum reached" flag is set. The resulting training byte is driven on every active lane, and `done` pulses once.

Top module: `lnd_negotiator`

## Requirements
- R1: During and directly after reset, `lane_set` is zero, `busy` and `done` are low, and the drive table holds no entries.
- R2: Lane k (k = 0..3) reads its request from the nibble at bits [4k+3:4k] of {`req_hi`,`req_lo`]. Lanes 0 and 2 therefore use low nibbles and lanes 1 and 3 high nibbles. Within a nibble, bits [1:0] are the swing request and bits [3:2] the pre-emphasis request.
- R3: The requested swing and pre-emphasis are each the maximum over lanes 0..`lane_cnt`-1 only. Nibbles of inactive lanes have no effect on the result.
- R4: The swing limit is the largest swing among written table entries. If the requested swing is greater than or equal to the limit, the 3-bit swing field is {1, limit}. Otherwise it is {0, request}.
- R5: The pre-emphasis limit is the largest pre-emphasis among written entries whose swing equals the two low bits of the chosen swing field. The 3-bit pre-emphasis field is {1, limit} when the request is greater than or equal to that limit, and {0, request} otherwise.
- R6: Byte k of `lane_set` (bits [8k+7:8k]) equals {2'b00, pre-emphasis field, swing field} for every active lane k and is 0x00 for inactive lanes. `lane_set` changes only in the cycle `done` is high.
- R7: `done` is a one-cycle pulse that rises exactly 2*`DEPTH` clock edges after the edge that accepted `start`, with `busy` high in between. A `start` seen while `busy` is high is ignored.
- R8: A table write made while the block is idle stores or replaces the entry at `tbl_idx`. A write made while `busy` is high is dropped and never takes effect.
- R9: With an empty table both limits are zero, so any request yields the fields {1,00} for swing and {1,00} for pre-emphasis, which gives a lane byte of 0x24.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_wr | input | 1 | Drive table write strobe |
| tbl_idx | input | IDX_W = clog2(DEPTH) | Drive table entry index |
| tbl_swing | input | 2 | Swing level of the written entry |
| tbl_pre | input | 2 | Pre-emphasis level of the written entry |
| start | input | 1 | Begin a negotiation with the current requests |
| req_lo | input | 8 | Requests of lanes 0 (low nibble) and 1 (high nibble) |
| req_hi | input | 8 | Requests of lanes 2 (low nibble) and 3 (high nibble) |
| lane_cnt | input | 3 | Number of active lanes (1, 2 or 4) |
| lane_set | output | 32 | Four training bytes, byte k for lane k |
| busy | output | 1 | A table scan is in progress |
| done | output | 1 | One-cycle pulse when `lane_set` is updated |

## Verification
Two functions of the block can fall into the same cycle. A table load can coincide with a running table scan, and a new `start` can coincide with a negotiation that is already in progress. Both cases are provoked in the middle of a scan. A table write that would raise both limits to their maximum is issued three cycles after `start`, and a second `start` carrying different requests is issued at the same point in another run. In each case the outcome is judged at the ports. The result must equal the one computed from the old table or the first requests. `done` must still arrive after exactly 2*`DEPTH` edges. A repeated run after the dropped write must still give the old table's answer, which shows the write was discarded rather than postponed.

// File: rtl/lnd_pkg.sv
package lnd_pkg;

    localparam int LND_LANES = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SWING = 2'd1,
        ST_PRE   = 2'd2
    } lnd_state_e;

    // Clamp a 2-bit request against a 2-bit limit; bit 2 flags the limit.
    function automatic logic [2:0] lnd_clamp(input logic [1:0] req,
                                             input logic [1:0] lim);
        if (req >= lim) begin
            return {1'b1, lim};
        end
        return {1'b0, req};
    endfunction

endpackage

// File: rtl/lnd_drive_table.sv
module lnd_drive_table #(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [1:0]       wr_swing,
    input  logic [1:0]       wr_pre,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [1:0]       rd_swing,
    output logic [1:0]       rd_pre
);

    logic [DEPTH-1:0] vld_d, vld_q;
    logic [1:0]       sw_d [DEPTH];
    logic [1:0]       sw_q [DEPTH];
    logic [1:0]       pe_d [DEPTH];
    logic [1:0]       pe_q [DEPTH];

    always_comb begin
        vld_d = vld_q;
        sw_d  = sw_q;
        pe_d  = pe_q;
        if (wr_en && (int'(wr_idx) < DEPTH)) begin
            vld_d[wr_idx] = 1'b1;
            sw_d[wr_idx]  = wr_swing;
            pe_d[wr_idx]  = wr_pre;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                sw_q[i] <= 2'd0;
                pe_q[i] <= 2'd0;
            end
        end else begin
            vld_q <= vld_d;
            sw_q  <= sw_d;
            pe_q  <= pe_d;
        end
    end

    assign rd_valid = vld_q[rd_idx];
    assign rd_swing = sw_q[rd_idx];
    assign rd_pre   = pe_q[rd_idx];

endmodule

// File: rtl/lnd_req_max.sv
module lnd_req_max (
    input  logic [7:0] req_lo,
    input  logic [7:0] req_hi,
    input  logic [2:0] lanes,
    output logic [1:0] max_swing,
    output logic [1:0] max_pre
);

    import lnd_pkg::*;

    logic [15:0] all_req;
    assign all_req = {req_hi, req_lo};

    always_comb begin
        logic [3:0] nib;
        max_swing = 2'd0;
        max_pre   = 2'd0;
        for (int i = 0; i < LND_LANES; i++) begin
            nib = all_req[4*i +: 4];
            if (i < int'(lanes)) begin
                if (nib[1:0] > max_swing) max_swing = nib[1:0];
                if (nib[3:2] > max_pre)   max_pre   = nib[3:2];
            end
        end
    end

endmodule

// File: rtl/lnd_lane_pack.sv
module lnd_lane_pack (
    input  logic [2:0]  swing_f,
    input  logic [2:0]  pre_f,
    input  logic [2:0]  lanes,
    output logic [31:0] word
);

    import lnd_pkg::*;

    for (genvar g = 0; g < LND_LANES; g++) begin : g_lane
        assign word[8*g +: 8] = (g < int'(lanes)) ? {2'b00, pre_f, swing_f} : 8'h00;
    end

endmodule

// File: rtl/lnd_negotiator.sv
module lnd_negotiator #(
    parameter  int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tbl_wr,
    input  logic [IDX_W-1:0] tbl_idx,
    input  logic [1:0]       tbl_swing,
    input  logic [1:0]       tbl_pre,
    input  logic             start,
    input  logic [7:0]       req_lo,
    input  logic [7:0]       req_hi,
    input  logic [2:0]       lane_cnt,
    output logic [31:0]      lane_set,
    output logic             busy,
    output logic             done
);

    import lnd_pkg::*;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    typedef struct packed {
        lnd_state_e       st;
        logic [IDX_W-1:0] idx;
        logic [7:0]       req_lo;
        logic [7:0]       req_hi;
        logic [2:0]       lanes;
        logic [1:0]       lim;
        logic [2:0]       swing_f;
        logic [1:0]       pre_acc;
        logic [31:0]      word;
        logic             done;
    } neg_state_t;

    neg_state_t r_d, r_q;

    logic       rd_valid;
    logic [1:0] rd_swing, rd_pre;
    logic [1:0] max_swing, max_pre;
    logic [1:0] pre_cand;
    logic [2:0] pre_f;
    logic [31:0] pack_word;
    logic       busy_w;

    assign busy_w = (r_q.st != ST_IDLE);

    lnd_drive_table #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_wr && !busy_w),
        .wr_idx   (tbl_idx),
        .wr_swing (tbl_swing),
        .wr_pre   (tbl_pre),
        .rd_idx   (r_q.idx),
        .rd_valid (rd_valid),
        .rd_swing (rd_swing),
        .rd_pre   (rd_pre)
    );

    lnd_req_max u_max (
        .req_lo    (r_q.req_lo),
        .req_hi    (r_q.req_hi),
        .lanes     (r_q.lanes),
        .max_swing (max_swing),
        .max_pre   (max_pre)
    );

    // Pre-emphasis candidate including the entry read this cycle.
    assign pre_cand = (rd_valid && (rd_swing == r_q.swing_f[1:0]) && (rd_pre > r_q.pre_acc))
                      ? rd_pre : r_q.pre_acc;
    assign pre_f    = lnd_clamp(max_pre, pre_cand);

    lnd_lane_pack u_pack (
        .swing_f (r_q.swing_f),
        .pre_f   (pre_f),
        .lanes   (r_q.lanes),
        .word    (pack_word)
    );

    always_comb begin
        logic [1:0] lim_cand;
        r_d      = r_q;
        r_d.done = 1'b0;
        lim_cand = (rd_valid && (rd_swing > r_q.lim)) ? rd_swing : r_q.lim;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st     = ST_SWING;
                    r_d.idx    = '0;
                    r_d.req_lo = req_lo;
                    r_d.req_hi = req_hi;
                    r_d.lanes  = lane_cnt;
                    r_d.lim    = 2'd0;
                end
            end
            ST_SWING: begin
                r_d.lim = lim_cand;
                if (r_q.idx == LAST_IDX) begin
                    r_d.swing_f = lnd_clamp(max_swing, lim_cand);
                    r_d.st      = ST_PRE;
                    r_d.idx     = '0;
                    r_d.pre_acc = 2'd0;
                end else begin
                    r_d.idx = r_q.idx + 1'b1;
                end
            end
            ST_PRE: begin
                r_d.pre_acc = pre_cand;
                if (r_q.idx == LAST_IDX) begin
                    r_d.word = pack_word;
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                    r_d.idx  = '0;
                end else begin
                    r_d.idx = r_q.idx + 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign lane_set = r_q.word;
    assign busy     = busy_w;
    assign done     = r_q.done;

endmodule

// File: rtl/lnd_negotiator_chk.sv
module lnd_negotiator_chk #(
    parameter int DEPTH = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic [31:0] lane_set
);

    int unsigned busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt <= 0;
        end else if (busy) begin
            busy_cnt <= busy_cnt + 1;
        end else begin
            busy_cnt <= 0;
        end
    end

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy_cnt == 32'(2 * DEPTH)));

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(lane_set));

    // R6
    pad_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_set & 32'hC0C0_C0C0) == 32'h0);

    // R6
    lane_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (lane_set[15:8] != 8'h00)) |-> (lane_set[15:8] == lane_set[7:0]));

endmodule

bind lnd_negotiator lnd_negotiator_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .lane_set (lane_set)
);

// File: tb/sim_lnd_negotiator.sv
module sim_lnd_negotiator;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;
    localparam int IDX_W      = $clog2(DEPTH);
    localparam int NVEC       = 9;

    // {req_lo, req_hi, lane_cnt, expected lane_set}
    localparam logic [50:0] VECS [NVEC] = '{
        {8'h00, 8'h00, 3'd4, 32'h0000_0000},  // R3 all zero
        {8'h21, 8'h00, 3'd1, 32'h0000_0001},  // R2 low nibble lane0
        {8'h21, 8'h00, 3'd2, 32'h0000_0606},  // R2 R4 high nibble lane1, swing clamp
        {8'h04, 8'h90, 3'd4, 32'h3131_3131},  // R5 pre clamp at swing 1
        {8'h04, 8'h90, 3'd2, 32'h0000_0808},  // R3 lane3 masked
        {8'hF0, 8'h00, 3'd4, 32'h2E2E_2E2E},  // R4 R5 both clamp
        {8'hF0, 8'h00, 3'd1, 32'h0000_0000},  // R3 lane1 ignored
        {8'h0B, 8'h00, 3'd1, 32'h0000_002E},  // R2 swing/pre bit split
        {8'h00, 8'h01, 3'd4, 32'h0101_0101}   // R2 lane2 low nibble of req_hi
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tbl_wr = 1'b0;
    logic [IDX_W-1:0] tbl_idx = '0;
    logic [1:0]       tbl_swing = 2'd0;
    logic [1:0]       tbl_pre = 2'd0;
    logic             start = 1'b0;
    logic [7:0]       req_lo = 8'h00;
    logic [7:0]       req_hi = 8'h00;
    logic [2:0]       lane_cnt = 3'd1;
    logic [31:0]      lane_set;
    logic             busy;
    logic             done;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] res;
    int          lat;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lnd_negotiator #(.DEPTH(DEPTH)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .tbl_wr    (tbl_wr),
        .tbl_idx   (tbl_idx),
        .tbl_swing (tbl_swing),
        .tbl_pre   (tbl_pre),
        .start     (start),
        .req_lo    (req_lo),
        .req_hi    (req_hi),
        .lane_cnt  (lane_cnt),
        .lane_set  (lane_set),
        .busy      (busy),
        .done      (done)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic load(input int idx, input logic [1:0] sw, input logic [1:0] pe);
        @(negedge clk);
        tbl_wr    = 1'b1;
        tbl_idx   = IDX_W'(idx);
        tbl_swing = sw;
        tbl_pre   = pe;
        @(negedge clk);
        tbl_wr = 1'b0;
    endtask

    // mode 1: second start mid-run; mode 2: table write mid-run
    task automatic run(input logic [7:0] lo, input logic [7:0] hi, input logic [2:0] lanes,
                       input int mode);
        @(negedge clk);
        start    = 1'b1;
        req_lo   = lo;
        req_hi   = hi;
        lane_cnt = lanes;
        @(negedge clk);
        start = 1'b0;
        lat   = 0;
        while (!done && lat < 100) begin
            if (lat == 3 && mode == 1) begin
                start    = 1'b1;
                req_lo   = 8'h00;
                req_hi   = 8'h00;
                lane_cnt = 3'd1;
            end
            if (lat == 3 && mode == 2) begin
                tbl_wr    = 1'b1;
                tbl_idx   = IDX_W'(4);
                tbl_swing = 2'd3;
                tbl_pre   = 2'd3;
            end
            if (lat == 4) begin
                start  = 1'b0;
                tbl_wr = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        res = lane_set;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 lane_set in reset", lane_set, 32'h0);
        check("R1 busy in reset", {31'b0, busy}, 32'h0);
        check("R1 done in reset", {31'b0, done}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 lane_set after reset", lane_set, 32'h0);

        // R9 empty table
        run(8'hFF, 8'hFF, 3'd4, 0);
        check("R9 empty table", res, 32'h2424_2424);
        check("R7 latency", 32'(lat), 32'(2 * DEPTH));

        load(0, 2'd0, 2'd0);
        load(1, 2'd0, 2'd3);
        load(2, 2'd1, 2'd2);
        load(3, 2'd2, 2'd1);

        for (int v = 0; v < NVEC; v++) begin
            run(VECS[v][50:43], VECS[v][42:35], VECS[v][34:32], 0);
            check($sformatf("R2/R3/R4/R5/R6 vector %0d", v), res, VECS[v][31:0]);
            check("R7 latency", 32'(lat), 32'(2 * DEPTH));
        end

        // R7 start while busy ignored
        run(8'hF0, 8'h00, 3'd4, 1);
        check("R7 start during busy", res, 32'h2E2E_2E2E);
        check("R7 latency with extra start", 32'(lat), 32'(2 * DEPTH));
        @(negedge clk);
        check("R7 idle after done", {31'b0, busy}, 32'h0);

        // R6 output held between runs
        repeat (5) @(negedge clk);
        check("R6 hold", lane_set, 32'h2E2E_2E2E);

        // R8 write during busy dropped
        run(8'hF0, 8'h00, 3'd4, 2);
        check("R8 write during scan", res, 32'h2E2E_2E2E);
        run(8'hF0, 8'h00, 3'd4, 0);
        check("R8 dropped write not applied later", res, 32'h2E2E_2E2E);
        load(4, 2'd3, 2'd3);
        run(8'hF0, 8'h00, 3'd4, 0);
        check("R8 idle write applied", res, 32'h3F3F_3F3F);
        load(4, 2'd1, 2'd0);
        run(8'hF0, 8'h00, 3'd4, 0);
        check("R8 entry replaced", res, 32'h2E2E_2E2E);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule